// File: doc/BRIEF.md
# Subroutine and Interrupt Stack Sequencer

This block is the multi-cycle control unit of an 8-bit processor that handles everything which moves the program counter or the status flags through the stack. It owns the 16-bit program counter, the 8-bit stack pointer and six status flags. It carries out the reset vector fetch, software break, return from interrupt, subroutine call and return, and single-byte push and pull of the accumulator or of the status byte. Opcode decode, instruction fetch, arithmetic and effective-address computation sit outside the block. The target of a call arrives already computed on `call_target`.

Memory is reached through a synchronous byte port that makes one access per cycle. A write (`mem_we`) commits at the clock edge. A read (`mem_re`) returns its byte on `mem_rdata` during the following cycle. A command is presented with `cmd_valid` and the encoded `cmd_op`. It is accepted only while the sequencer is idle, and `done` marks the end of the command.

The state machine has these states, each named in its own state code:

- **S_RESET**: held in reset.
- **S_IDLE**: waiting for a command.
- **S_VEC_LO** and **S_VEC_HI**: vector reads.
- **S_PUSH_HI**, **S_PUSH_LO** and **S_PUSH_P**: return-address and status pushes.
- **S_PUSH_1**: single-byte push.
- **S_PULL_P**, **S_PULL_LO** and **S_PULL_HI**: status and return-address pulls.
- **S_PULL_1**: single-byte pull.
- **S_FINISH**: completion cycle that asserts `done`.

The transitions follow each command:

- **Reset**: S_RESET → S_VEC_LO → S_VEC_HI → S_FINISH.
- **Call**: S_IDLE → S_PUSH_HI → S_PUSH_LO → S_FINISH.
- **Break**: S_IDLE → S_PUSH_HI → S_PUSH_LO → S_PUSH_P → S_VEC_LO → S_VEC_HI → S_FINISH.
- **Return**: S_IDLE → S_PULL_LO → S_PULL_HI → S_FINISH.
- **Return from interrupt**: S_IDLE → S_PULL_P → S_PULL_LO → S_PULL_HI → S_FINISH.
- **Single-byte push**: S_IDLE → S_PUSH_1 → S_FINISH.
- **Single-byte pull**: S_IDLE → S_PULL_1 → S_FINISH.

From S_FINISH the machine always returns to S_IDLE.

Top module: `stack_sequencer`

## Requirements
- R1: After `rst_n` rises, the block reads 0xFFFC in the first cycle and 0xFFFD in the second. `done` pulses in the third cycle. From then on `pc_o` = {byte@0xFFFD, byte@0xFFFC}, `sp_o` = 0xFF and `flags_o` = 6'b000100.
- R2: Every push writes address 0x0100+S and then decrements S modulo 256, so a push at S=0x00 writes 0x0100 and leaves S=0xFF.
- R3: Every pull increments S modulo 256 and then reads 0x0100+S, so a pull at S=0xFF reads 0x0100 and leaves S=0x00.
- R4: Call (`cmd_op`=0) pushes (PC−1) mod 65536, high byte first and low byte second, and then loads PC with `call_target`.
- R5: Return (`cmd_op`=1) pulls the low byte and then the high byte, and loads PC with that 16-bit value plus 1, modulo 65536.
- R6: Break (`cmd_op`=2) pushes PC high, PC low and then the status byte with bit 4 = 1. It then reads 0xFFFE (new PC low) and 0xFFFF (new PC high) and sets the interrupt-disable flag.
- R7: Return from interrupt (`cmd_op`=3) pulls the status byte, then the PC low byte, then the PC high byte, and loads PC with that value unchanged.
- R8: The status byte is laid out as {N, V, 1, B, D, I, Z, C}, bit 7 to bit 0. `flags_o` is {N, V, D, I, Z, C}. Status push (`cmd_op`=5) writes B = 1.
- R9: Status pull (`cmd_op`=7) and the status pull of R7 load N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0. Bits 5 and 4 of the pulled byte have no effect.
- R10: Accumulator pull (`cmd_op`=6) shows the byte on `acc_o` with `acc_load`=1 in the `done` cycle. It sets Z = (byte==0) and N = bit 7, and leaves the other flags unchanged.
- R11: Accumulator push (`cmd_op`=4) writes the `acc_i` value that was sampled when the command was accepted.
- R12: `done` is high for exactly one cycle, the cycle after the last memory access. `busy` is high from acceptance through the `done` cycle, and read and write never coincide.
- R13: `cmd_valid` while `busy` is high has no effect on the access sequence or on the final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_op | input | 3 | Command code (0 call, 1 return, 2 break, 3 return from interrupt, 4 push acc, 5 push status, 6 pull acc, 7 pull status) |
| call_target | input | 16 | Destination of a call |
| acc_i | input | 8 | Accumulator value for a push |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| acc_o | output | 8 | Pulled accumulator byte |
| acc_load | output | 1 | `acc_o` is valid and must be loaded |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| flags_o | output | 6 | {N, V, D, I, Z, C} |
| busy | output | 1 | Command in progress (or in reset) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first memory access of a command appears one cycle after the clock edge that accepts it. Each further access follows on the next cycle, and `done` comes one cycle after the last access. The new PC, S and flags become visible one cycle later still, together with the return of `busy` to 0. The bench turns each command into a behavioural queue of expected accesses. It compares the queue head against the memory port at every falling edge, then checks `done`, `acc_o` and `acc_load` in the cycle after the queue empties, and the register outputs in the cycle after that. It keeps driving a different command while busy, so any premature acceptance shows up as a mismatched access.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

    typedef enum logic [2:0] {
        CMD_CALL  = 3'd0,
        CMD_RET   = 3'd1,
        CMD_BRK   = 3'd2,
        CMD_RETI  = 3'd3,
        CMD_PUSHA = 3'd4,
        CMD_PUSHF = 3'd5,
        CMD_PULLA = 3'd6,
        CMD_PULLF = 3'd7
    } cmd_e;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE, S_VEC_LO, S_VEC_HI,
        S_PUSH_HI, S_PUSH_LO, S_PUSH_P, S_PUSH_1,
        S_PULL_P, S_PULL_LO, S_PULL_HI, S_PULL_1,
        S_FINISH
    } state_e;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

    // Status byte: {N, V, 1, B, D, I, Z, C}
    function automatic logic [7:0] pack_status(input flags_t f, input logic brk);
        return {f.n, f.v, 1'b1, brk, f.d, f.i, f.z, f.c};
    endfunction

    function automatic flags_t unpack_status(input logic [7:0] b);
        flags_t f;
        f.n = b[7];
        f.v = b[6];
        f.d = b[3];
        f.i = b[2];
        f.z = b[1];
        f.c = b[0];
        return f;
    endfunction

endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp #(
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter logic [7:0] SP_RESET   = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_step,
    input  logic        pull_step,
    output logic [7:0]  sp_o,
    output logic [15:0] push_addr,
    output logic [15:0] pull_addr
);
    logic [7:0] sp_q;
    logic [7:0] sp_inc;

    assign sp_inc    = sp_q + 8'd1;
    assign push_addr = {STACK_PAGE, sp_q};
    assign pull_addr = {STACK_PAGE, sp_inc};
    assign sp_o      = sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sp_q <= SP_RESET;
        else if (push_step)
            sp_q <= sp_q - 8'd1;
        else if (pull_step)
            sp_q <= sp_inc;
    end

    // R2
    sp_push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_step |=> sp_q == $past(sp_q) - 8'd1);

    // R3
    sp_pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pull_step |=> sp_q == $past(sp_q) + 8'd1);

endmodule

// File: rtl/stkseq_flags.sv
module stkseq_flags
    import stkseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_all,
    input  logic [7:0] all_byte,
    input  logic       ld_zn,
    input  logic [7:0] zn_byte,
    input  logic       set_i,
    output flags_t     flags_o
);
    flags_t fl_q;

    assign flags_o = fl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q   <= '0;
            fl_q.i <= 1'b1;
        end else if (ld_all) begin
            fl_q <= unpack_status(all_byte);
        end else begin
            if (ld_zn) begin
                fl_q.z <= (zn_byte == 8'h00);
                fl_q.n <= zn_byte[7];
            end
            if (set_i)
                fl_q.i <= 1'b1;
        end
    end

    // R6
    fl_set_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> fl_q.i);

    // R10
    fl_zn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_zn && !ld_all) |=> (fl_q.c == $past(fl_q.c)) && (fl_q.v == $past(fl_q.v))
                               && (fl_q.d == $past(fl_q.d)));

endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
    import stkseq_pkg::*;
#(
    parameter logic [15:0] VEC_RESET  = 16'hFFFC,
    parameter logic [15:0] VEC_BREAK  = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  SP_RESET   = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [15:0] call_target,
    input  logic [7:0]  acc_i,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  acc_o,
    output logic        acc_load,
    output logic [15:0] pc_o,
    output logic [7:0]  sp_o,
    output logic [5:0]  flags_o,
    output logic        busy,
    output logic        done
);
    state_e      st_q, st_nx;
    cmd_e        op_q;
    logic [15:0] pc_q, ret_q, tgt_q;
    logic [7:0]  lo_q;
    logic        boot_q;

    logic        push_step, pull_step;
    logic [15:0] push_addr, pull_addr, vec_addr;
    logic        ld_all, ld_zn, set_i;
    flags_t      fl;
    logic        finish_cmd;

    stkseq_sp #(.STACK_PAGE(STACK_PAGE), .SP_RESET(SP_RESET)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_step (push_step),
        .pull_step (pull_step),
        .sp_o      (sp_o),
        .push_addr (push_addr),
        .pull_addr (pull_addr)
    );

    stkseq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_all   (ld_all),
        .all_byte (mem_rdata),
        .ld_zn    (ld_zn),
        .zn_byte  (mem_rdata),
        .set_i    (set_i),
        .flags_o  (fl)
    );

    assign vec_addr   = boot_q ? VEC_RESET : VEC_BREAK;
    assign finish_cmd = (st_q == S_FINISH) && !boot_q;
    assign pc_o       = pc_q;
    assign flags_o    = fl;
    assign acc_o      = mem_rdata;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= S_RESET;
        else
            st_q <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_RESET:   st_nx = S_VEC_LO;
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_e'(cmd_op))
                        CMD_CALL, CMD_BRK:     st_nx = S_PUSH_HI;
                        CMD_RET:               st_nx = S_PULL_LO;
                        CMD_RETI:              st_nx = S_PULL_P;
                        CMD_PUSHA, CMD_PUSHF:  st_nx = S_PUSH_1;
                        CMD_PULLA, CMD_PULLF:  st_nx = S_PULL_1;
                        default:               st_nx = S_IDLE;
                    endcase
                end
            end
            S_PUSH_HI: st_nx = S_PUSH_LO;
            S_PUSH_LO: st_nx = (op_q == CMD_BRK) ? S_PUSH_P : S_FINISH;
            S_PUSH_P:  st_nx = S_VEC_LO;
            S_VEC_LO:  st_nx = S_VEC_HI;
            S_VEC_HI:  st_nx = S_FINISH;
            S_PULL_P:  st_nx = S_PULL_LO;
            S_PULL_LO: st_nx = S_PULL_HI;
            S_PULL_HI: st_nx = S_FINISH;
            S_PUSH_1:  st_nx = S_FINISH;
            S_PULL_1:  st_nx = S_FINISH;
            S_FINISH:  st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        push_step = 1'b0;
        pull_step = 1'b0;
        busy      = (st_q != S_IDLE);
        done      = (st_q == S_FINISH);
        unique case (st_q)
            S_PUSH_HI: begin
                mem_we = 1'b1; mem_addr = push_addr; mem_wdata = ret_q[15:8]; push_step = 1'b1;
            end
            S_PUSH_LO: begin
                mem_we = 1'b1; mem_addr = push_addr; mem_wdata = ret_q[7:0]; push_step = 1'b1;
            end
            S_PUSH_P: begin
                mem_we = 1'b1; mem_addr = push_addr; mem_wdata = pack_status(fl, 1'b1);
                push_step = 1'b1;
            end
            S_PUSH_1: begin
                mem_we    = 1'b1;
                mem_addr  = push_addr;
                mem_wdata = (op_q == CMD_PUSHA) ? ret_q[7:0] : pack_status(fl, 1'b1);
                push_step = 1'b1;
            end
            S_VEC_LO: begin
                mem_re = 1'b1; mem_addr = vec_addr;
            end
            S_VEC_HI: begin
                mem_re = 1'b1; mem_addr = vec_addr + 16'd1;
            end
            S_PULL_P, S_PULL_LO, S_PULL_HI, S_PULL_1: begin
                mem_re = 1'b1; mem_addr = pull_addr; pull_step = 1'b1;
            end
            default: ;
        endcase
    end

    // Flag and accumulator strobes
    always_comb begin
        ld_all   = ((st_q == S_PULL_LO) && (op_q == CMD_RETI)) ||
                   (finish_cmd && (op_q == CMD_PULLF));
        ld_zn    = finish_cmd && (op_q == CMD_PULLA);
        set_i    = finish_cmd && (op_q == CMD_BRK);
        acc_load = ld_zn;
    end

    // Command latch and program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= CMD_CALL;
            pc_q   <= '0;
            ret_q  <= '0;
            tgt_q  <= '0;
            lo_q   <= '0;
            boot_q <= 1'b1;
        end else begin
            if (st_q == S_IDLE && cmd_valid) begin
                op_q  <= cmd_e'(cmd_op);
                tgt_q <= call_target;
                unique case (cmd_e'(cmd_op))
                    CMD_CALL: ret_q <= pc_q - 16'd1;
                    CMD_BRK:  ret_q <= pc_q;
                    default:  ret_q <= {8'h00, acc_i};
                endcase
            end
            if (st_q == S_VEC_HI || st_q == S_PULL_HI)
                lo_q <= mem_rdata;
            if (st_q == S_FINISH) begin
                boot_q <= 1'b0;
                if (boot_q)
                    pc_q <= {mem_rdata, lo_q};
                else begin
                    unique case (op_q)
                        CMD_CALL:          pc_q <= tgt_q;
                        CMD_RET:           pc_q <= {mem_rdata, lo_q} + 16'd1;
                        CMD_BRK, CMD_RETI: pc_q <= {mem_rdata, lo_q};
                        default:           pc_q <= pc_q;
                    endcase
                end
            end
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R13
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_FINISH) |=> $stable(pc_q));

    // R8
    status_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_PUSH_P) |-> (mem_we && mem_wdata[5] && mem_wdata[4]));

    // R12
    busy_in_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/tb_stack_sequencer.sv
`timescale 1ns/1ps
module tb_stack_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] call_target = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  acc_o;
    logic        acc_load;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;
    logic [5:0]  flags_o;
    logic        busy, done;

    always #2.5 clk = ~clk;

    stack_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .call_target(call_target), .acc_i(acc_i), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .acc_o(acc_o), .acc_load(acc_load),
        .pc_o(pc_o), .sp_o(sp_o), .flags_o(flags_o), .busy(busy), .done(done)
    );

    // Environment memory, written by the design
    logic [7:0] mem  [int];
    // Reference model memory
    logic [7:0] rmem [int];

    always @(posedge clk) begin
        if (mem_re)
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        if (mem_we)
            mem[int'(mem_addr)] = mem_wdata;
    end

    int tests = 0;
    int fails = 0;

    // Reference model state
    int         m_pc = 0;
    int         m_sp = 0;
    logic [5:0] m_fl = '0;
    int         m_acc = 0;
    bit         m_load = 0;
    int q_we[$];
    int q_addr[$];
    int q_wd[$];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    function automatic int rget(input int a);
        return rmem.exists(a) ? int'(rmem[a]) : 0;
    endfunction

    function automatic int m_status();
        return int'({m_fl[5], m_fl[4], 1'b1, 1'b1, m_fl[3:0]});
    endfunction

    function automatic void m_push(input int b);
        q_we.push_back(1); q_addr.push_back(32'h100 + m_sp); q_wd.push_back(b & 255);
        rmem[32'h100 + m_sp] = 8'(b);
        m_sp = (m_sp - 1) & 255;
    endfunction

    function automatic int m_pull();
        m_sp = (m_sp + 1) & 255;
        q_we.push_back(0); q_addr.push_back(32'h100 + m_sp); q_wd.push_back(0);
        return rget(32'h100 + m_sp);
    endfunction

    function automatic int m_read(input int a);
        q_we.push_back(0); q_addr.push_back(a); q_wd.push_back(0);
        return rget(a);
    endfunction

    function automatic void m_load_status(input int b);
        logic [7:0] s;
        s = 8'(b);
        m_fl = {s[7], s[6], s[3:0]};
    endfunction

    // Compare accesses, done, then final registers
    task automatic run_seq(input string rq, input bit junk);
        while (q_we.size() > 0) begin
            int w, a, d;
            w = q_we.pop_front(); a = q_addr.pop_front(); d = q_wd.pop_front();
            chk(mem_we == w[0] && mem_re == !w[0], {rq, "/R12 strobes"}, {mem_we, mem_re}, {w[0], !w[0]});
            chk(mem_addr == a[15:0], {rq, "/R13 address"}, mem_addr, a);
            if (w[0]) chk(mem_wdata == d[7:0], {rq, " wdata"}, mem_wdata, d);
            chk(!done, "R12 no early done", done, 0);
            @(negedge clk);
            if (junk) begin
                cmd_valid = 1'b1; cmd_op = cmd_op ^ 3'd3; call_target = 16'hDEAD; acc_i = 8'hEE;
            end
        end
        cmd_valid = 1'b0;
        chk(done && busy, "R12 done pulse", {done, busy}, 2'b11);
        chk(acc_load == m_load, "R10 acc_load", acc_load, m_load);
        if (m_load) chk(acc_o == m_acc[7:0], "R10 acc_o", acc_o, m_acc);
        @(negedge clk);
        chk(!done && !busy, "R12 done one cycle", {done, busy}, 2'b00);
        chk(pc_o == m_pc[15:0], {rq, " pc"}, pc_o, m_pc);
        chk(sp_o == m_sp[7:0], {rq, " sp"}, sp_o, m_sp);
        chk(flags_o == m_fl, {rq, " flags"}, flags_o, m_fl);
    endtask

    task automatic do_cmd(input int op, input int tgt, input int acc, input string rq);
        int lo, hi, b, r;
        m_load = 0;
        case (op)
            0: begin r = (m_pc - 1) & 16'hFFFF; m_push(r >> 8); m_push(r); m_pc = tgt; end
            1: begin lo = m_pull(); hi = m_pull(); m_pc = ((hi << 8) + lo + 1) & 16'hFFFF; end
            2: begin
                m_push(m_pc >> 8); m_push(m_pc); m_push(m_status());
                lo = m_read(16'hFFFE); hi = m_read(16'hFFFF);
                m_pc = (hi << 8) + lo; m_fl[2] = 1'b1;
            end
            3: begin b = m_pull(); m_load_status(b); lo = m_pull(); hi = m_pull(); m_pc = (hi << 8) + lo; end
            4: m_push(acc);
            5: m_push(m_status());
            6: begin
                b = m_pull(); m_acc = b; m_load = 1;
                m_fl[5] = b[7]; m_fl[1] = (b == 0);
            end
            default: begin b = m_pull(); m_load_status(b); end
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); call_target = 16'(tgt); acc_i = 8'(acc);
        @(negedge clk);
        cmd_op = 3'(op) ^ 3'd1;
        run_seq(rq, 1'b1);
    endtask

    initial begin
        mem[32'hFFFC] = 8'h34; mem[32'hFFFD] = 8'h12;
        mem[32'hFFFE] = 8'h00; mem[32'hFFFF] = 8'h90;
        rmem[32'hFFFC] = 8'h34; rmem[32'hFFFD] = 8'h12;
        rmem[32'hFFFE] = 8'h00; rmem[32'hFFFF] = 8'h90;
        repeat (3) @(negedge clk);
        chk(busy && !done && !mem_we && !mem_re, "R1 held in reset", {busy, done, mem_we, mem_re}, 4'b1000);
        rst_n = 1'b1;
        m_sp = 8'hFF; m_fl = 6'b000100; m_load = 0;
        void'(m_read(16'hFFFC)); void'(m_read(16'hFFFD));
        m_pc = 16'h1234;
        @(negedge clk);
        run_seq("R1", 1'b0);

        do_cmd(4, 0, 8'h5A, "R11 push acc R2");
        do_cmd(5, 0, 0,     "R8 push status");
        do_cmd(7, 0, 0,     "R9 pull status");
        do_cmd(6, 0, 0,     "R10 pull acc");
        do_cmd(6, 0, 0,     "R3 wrap pull");
        do_cmd(4, 0, 8'h80, "R2 wrap push");
        do_cmd(6, 0, 0,     "R10 negative");
        do_cmd(4, 0, 8'hC3, "R11 push");
        do_cmd(7, 0, 0,     "R9 load flags");
        do_cmd(4, 0, 8'h3C, "R11 push");
        do_cmd(7, 0, 0,     "R9 bits 5,4 ignored");
        do_cmd(0, 16'h4000, 0, "R4 call");
        do_cmd(1, 0, 0,     "R5 return");
        do_cmd(2, 0, 0,     "R6 break");
        do_cmd(3, 0, 0,     "R7 return from interrupt");
        do_cmd(0, 16'h0000, 0, "R4 call to zero");
        do_cmd(0, 16'h5555, 0, "R4 pc-1 wrap");
        do_cmd(1, 0, 0,     "R5 return wrap");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule